// File: doc/BRIEF.md
# Sequential Four-Channel PWM Fade Sequencer

This block drives four PWM lines that light up one after another for a sequential turn-indicator animation. When the trigger input rises, channel 0 waits a first delay, and each later channel waits one more shared step delay after the channel before it. Each channel then ramps its duty cycle upward through a fixed non-linear step table, from the configured minimum duty to the configured maximum duty. When the trigger falls, every channel goes back to the minimum duty with no ramp, and any delay or ramp still pending is cancelled.

A configuration interface holds six values: minimum duty, maximum duty, frequency code, slew count, first delay and step delay. The sequencer runs only while both the enable and the start controls are high. It copies the configuration into shadow storage while it is stopped and freezes the copy while it runs. A trigger-out goes high while channel 1 is ramping or holding, so it can drive the trigger input of a second unit in a chain. All pins are plain level signals with no handshake: the block samples the trigger and controls on every clock and has no back-pressure.

Top module: `seq_fade_sequencer`

## Requirements
- R1: After reset, all PWM outputs and trigger-out are 0.
- R2: While enable or start is low, the PWM outputs are 0 from the next clock, and the configuration inputs are copied into shadow storage every cycle. While both are high, changes to the configuration inputs have no effect on any output.
- R3: The PWM period is 127 phases of (32 - frequency code) clocks each. A channel is high during the first D phases of each period, where D is its loaded 7-bit duty. Duty 127 is constantly high and duty 0 is constantly low.
- R4: A channel's loaded duty changes only at the end of a PWM period (the last clock of phase 126). At that point it takes the channel's target duty.
- R5: A trigger rise is the trigger sampled high at a clock edge when it was low at the previous edge. Channel c enters its ramp (first delay + c × step delay + 1) clocks after the edge that sees the rise.
- R6: The step table has entries s(i) = floor(127·i·(i+176)/61952) for i = 0..176. A ramp starts at the first index whose entry is at least the minimum duty. It advances one index every max(slew,1) clocks. The target is s(index) until the index reaches the first index whose entry is at least the maximum duty. From then on the target is exactly the maximum duty.
- R7: On a trigger fall, every channel's target becomes the minimum duty at once, and pending delays and ramps are cancelled. A later rise restarts the whole sequence from channel 0.
- R8: Trigger-out is high exactly while channel 1 is ramping or holding its maximum.
- R9: A trigger that is already high when the sequencer is started counts as a rise at the first running edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Animation trigger level |
| sm_enable | input | 1 | Sequencer enable |
| sm_start | input | 1 | Sequencer start |
| cfg_duty_min | input | 7 | Minimum duty (resting level) |
| cfg_duty_max | input | 7 | Maximum duty (end of ramp) |
| cfg_freq | input | 5 | Frequency code, higher is faster |
| cfg_slew | input | 16 | Clocks per ramp step |
| cfg_delay_first | input | 16 | Clocks from trigger rise to channel 0 start |
| cfg_delay_step | input | 16 | Clocks between starts of adjacent channels |
| pwm_out | output | 4 | PWM lines, bit c is channel c |
| trig_out | output | 1 | Cascade trigger, follows channel 1 activity |

## Verification
The assertions check on every cycle the rules that need no timing context. The phase stays in range. A loaded duty moves only at a period boundary. The ramp index never jumps or leaves the table. A stopped sequencer drives its outputs low. Trigger-out never runs ahead of channel 0, and a trigger fall clears trigger-out. Only the bench's scenarios can show the staggered start latency, the exact duty a finished ramp settles to, the frozen shadow configuration, the restart after a mid-sequence fall and the rise seen when starting with the trigger already high. The bench checks these against a behavioural model on every clock and with directed measurements.

// File: rtl/seq_fade_pkg.sv
package seq_fade_pkg;
  localparam int DUTY_W    = 7;
  localparam int DUTY_FULL = (1 << DUTY_W) - 1;
  localparam int PH_LAST   = DUTY_FULL - 1;
  localparam int STEP_LAST = 176;
  localparam int IDX_W     = $clog2(STEP_LAST + 2);
  localparam int STEP_DEN  = STEP_LAST * 2 * STEP_LAST;

  typedef enum logic [1:0] {
    LANE_IDLE = 2'd0,
    LANE_WAIT = 2'd1,
    LANE_RAMP = 2'd2
  } lane_state_e;

  // Convex brightness curve: 0 at index 0, full scale at the last index.
  function automatic logic [DUTY_W-1:0] step_level(input logic [IDX_W-1:0] i);
    int n;
    n = DUTY_FULL * int'(i) * (int'(i) + STEP_LAST);
    return DUTY_W'(n / STEP_DEN);
  endfunction

  // First table index whose level reaches lvl (count of entries below it).
  function automatic logic [IDX_W-1:0] first_index(input logic [DUTY_W-1:0] lvl);
    int cnt;
    cnt = 0;
    for (int k = 0; k <= STEP_LAST; k++) begin
      if (step_level(IDX_W'(k)) < lvl) cnt++;
    end
    return IDX_W'(cnt);
  endfunction
endpackage

// File: rtl/seq_fade_timebase.sv
module seq_fade_timebase
  import seq_fade_pkg::*;
#(
  parameter int FREQ_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [FREQ_W-1:0] freq_code,
  output logic              tick,
  output logic              wrap,
  output logic [DUTY_W-1:0] phase
);
  localparam int DIV_W = FREQ_W + 1;

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] pcnt;

  assign div  = DIV_W'(2 ** FREQ_W) - DIV_W'(freq_code);
  assign tick = run && (pcnt == div - DIV_W'(1));
  assign wrap = tick && (phase == DUTY_W'(PH_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt  <= '0;
      phase <= '0;
    end else if (tick) begin
      pcnt  <= '0;
      phase <= (phase == DUTY_W'(PH_LAST)) ? '0 : phase + DUTY_W'(1);
    end else begin
      pcnt <= pcnt + DIV_W'(1);
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= DUTY_W'(PH_LAST)); // R3

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> ($stable(phase) || phase == '0)); // R3
endmodule

// File: rtl/seq_fade_lane.sv
module seq_fade_lane
  import seq_fade_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEQ_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rise,
  input  logic              fall,
  input  logic [SEQ_W-1:0]  seq_cnt,
  input  logic [SEQ_W-1:0]  start_at,
  input  logic [IDX_W-1:0]  idx_lo,
  input  logic [IDX_W-1:0]  idx_hi,
  input  logic [CNT_W-1:0]  slew,
  input  logic [DUTY_W-1:0] duty_min,
  input  logic [DUTY_W-1:0] duty_max,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] phase,
  output logic              pwm,
  output logic              ramping
);
  lane_state_e       st;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  scnt;
  logic [DUTY_W-1:0] cmp;
  logic [DUTY_W-1:0] target;
  logic [CNT_W:0]    slew_eff;
  logic              step_due;

  assign slew_eff = (slew == '0) ? (CNT_W+1)'(1) : {1'b0, slew};
  assign step_due = ({1'b0, scnt} + (CNT_W+1)'(1)) >= slew_eff;

  always_comb begin
    if (st == LANE_RAMP)
      target = (idx >= idx_hi) ? duty_max : step_level(idx);
    else
      target = duty_min;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      st   <= LANE_IDLE;
      idx  <= '0;
      scnt <= '0;
      cmp  <= '0;
    end else begin
      if (wrap) cmp <= target;
      if (rise) begin
        st   <= LANE_WAIT;
        idx  <= '0;
        scnt <= '0;
      end else if (fall) begin
        st <= LANE_IDLE;
      end else if (st == LANE_WAIT && seq_cnt == start_at) begin
        st   <= LANE_RAMP;
        idx  <= idx_lo;
        scnt <= '0;
      end else if (st == LANE_RAMP && idx < idx_hi) begin
        if (step_due) begin
          idx  <= idx + IDX_W'(1);
          scnt <= '0;
        end else begin
          scnt <= scnt + CNT_W'(1);
        end
      end
    end
  end

  assign pwm     = phase < cmp;
  assign ramping = (st == LANE_RAMP);

  AST_CMP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(cmp) || cmp == '0)); // R4

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LANE_RAMP) |-> (idx <= IDX_W'(STEP_LAST))); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LANE_RAMP && $past(st) == LANE_RAMP) |->
      (idx == $past(idx) || idx == $past(idx) + IDX_W'(1))); // R6

  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == DUTY_W'(DUTY_FULL)) |-> pwm); // R3
endmodule

// File: rtl/seq_fade_sequencer.sv
module seq_fade_sequencer
  import seq_fade_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int FREQ_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              sm_enable,
  input  logic              sm_start,
  input  logic [DUTY_W-1:0] cfg_duty_min,
  input  logic [DUTY_W-1:0] cfg_duty_max,
  input  logic [FREQ_W-1:0] cfg_freq,
  input  logic [CNT_W-1:0]  cfg_slew,
  input  logic [CNT_W-1:0]  cfg_delay_first,
  input  logic [CNT_W-1:0]  cfg_delay_step,
  output logic [N_CH-1:0]   pwm_out,
  output logic              trig_out
);
  localparam int SEQ_W = CNT_W + $clog2(N_CH) + 1;

  logic              run;
  logic              trig_q;
  logic              rise;
  logic              fall;
  logic [DUTY_W-1:0] sh_min;
  logic [DUTY_W-1:0] sh_max;
  logic [FREQ_W-1:0] sh_freq;
  logic [CNT_W-1:0]  sh_slew;
  logic [CNT_W-1:0]  sh_d0;
  logic [CNT_W-1:0]  sh_dstep;
  logic [SEQ_W-1:0]  seq_cnt;
  logic [IDX_W-1:0]  idx_lo;
  logic [IDX_W-1:0]  idx_hi;
  logic              tick;
  logic              wrap;
  logic [DUTY_W-1:0] phase;
  logic [N_CH-1:0]   ramping;

  assign run  = sm_enable && sm_start;
  assign rise = run && trig_in && !trig_q;
  assign fall = run && !trig_in && trig_q;

  // Shadow configuration: tracks inputs while stopped, frozen while running.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_min   <= '0;
      sh_max   <= '0;
      sh_freq  <= '0;
      sh_slew  <= '0;
      sh_d0    <= '0;
      sh_dstep <= '0;
    end else if (!run) begin
      sh_min   <= cfg_duty_min;
      sh_max   <= cfg_duty_max;
      sh_freq  <= cfg_freq;
      sh_slew  <= cfg_slew;
      sh_d0    <= cfg_delay_first;
      sh_dstep <= cfg_delay_step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      trig_q  <= 1'b0;
      seq_cnt <= '0;
    end else begin
      trig_q <= trig_in;
      if (rise)
        seq_cnt <= '0;
      else if (seq_cnt != {SEQ_W{1'b1}})
        seq_cnt <= seq_cnt + SEQ_W'(1);
    end
  end

  always_comb begin
    idx_lo = first_index(sh_min);
    idx_hi = first_index(sh_max);
  end

  seq_fade_timebase #(.FREQ_W(FREQ_W)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .freq_code (sh_freq),
    .tick      (tick),
    .wrap      (wrap),
    .phase     (phase)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_lane
      logic [SEQ_W-1:0] start_at;
      assign start_at = SEQ_W'(sh_d0) + SEQ_W'(c) * SEQ_W'(sh_dstep);

      seq_fade_lane #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rise     (rise),
        .fall     (fall),
        .seq_cnt  (seq_cnt),
        .start_at (start_at),
        .idx_lo   (idx_lo),
        .idx_hi   (idx_hi),
        .slew     (sh_slew),
        .duty_min (sh_min),
        .duty_max (sh_max),
        .wrap     (wrap),
        .phase    (phase),
        .pwm      (pwm_out[c]),
        .ramping  (ramping[c])
      );
    end
  endgenerate

  if (N_CH > 1) begin : g_cascade
    assign trig_out = ramping[1];
  end else begin : g_cascade_single
    assign trig_out = ramping[0];
  end

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_out == '0)); // R2

  AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> ramping[0]); // R8

  AST_FALL_CLEARS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fall) |=> !trig_out); // R7
endmodule

// File: tb/seq_fade_sequencer_test.sv
module seq_fade_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0;
  logic        sm_enable = 1'b0;
  logic        sm_start = 1'b0;
  logic [6:0]  cfg_duty_min = '0;
  logic [6:0]  cfg_duty_max = '0;
  logic [4:0]  cfg_freq = '0;
  logic [15:0] cfg_slew = '0;
  logic [15:0] cfg_delay_first = '0;
  logic [15:0] cfg_delay_step = '0;
  logic [3:0]  pwm_out;
  logic        trig_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seq_fade_sequencer uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .sm_enable(sm_enable), .sm_start(sm_start),
    .cfg_duty_min(cfg_duty_min), .cfg_duty_max(cfg_duty_max),
    .cfg_freq(cfg_freq), .cfg_slew(cfg_slew),
    .cfg_delay_first(cfg_delay_first), .cfg_delay_step(cfg_delay_step),
    .pwm_out(pwm_out), .trig_out(trig_out)
  );

  // ---------------- behavioural reference model ----------------
  int tbl[0:176];
  int s_min, s_max, s_freq, s_slew, s_d0, s_ds;
  int tq, cnt, pc, ph;
  int st[4], idx[4], sc[4], cmpv[4];

  function automatic int lvl_index(int lvl);
    for (int i = 0; i <= 176; i++) if (tbl[i] >= lvl) return i;
    return 177;
  endfunction

  initial begin
    for (int i = 0; i <= 176; i++) tbl[i] = (127 * i * (i + 176)) / 61952;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      s_min = 0; s_max = 0; s_freq = 0; s_slew = 0; s_d0 = 0; s_ds = 0;
      tq = 0; cnt = 0; pc = 0; ph = 0;
      for (int c = 0; c < 4; c++) begin st[c] = 0; idx[c] = 0; sc[c] = 0; cmpv[c] = 0; end
    end else if (!(sm_enable && sm_start)) begin
      s_min = cfg_duty_min; s_max = cfg_duty_max; s_freq = cfg_freq;
      s_slew = cfg_slew; s_d0 = cfg_delay_first; s_ds = cfg_delay_step;
      tq = 0; cnt = 0; pc = 0; ph = 0;
      for (int c = 0; c < 4; c++) begin st[c] = 0; idx[c] = 0; sc[c] = 0; cmpv[c] = 0; end
    end else begin
      int div, lo, hi, slw;
      bit rise, fall, tick, wrap;
      rise = trig_in && (tq == 0);
      fall = !trig_in && (tq == 1);
      div  = 32 - s_freq;
      tick = (pc == div - 1);
      wrap = tick && (ph == 126);
      lo   = lvl_index(s_min);
      hi   = lvl_index(s_max);
      slw  = (s_slew == 0) ? 1 : s_slew;
      for (int c = 0; c < 4; c++) begin
        int tgt;
        if (st[c] == 2) tgt = (idx[c] >= hi) ? s_max : tbl[idx[c]];
        else tgt = s_min;
        if (wrap) cmpv[c] = tgt;
        if (rise) begin st[c] = 1; idx[c] = 0; sc[c] = 0; end
        else if (fall) st[c] = 0;
        else if (st[c] == 1 && cnt == s_d0 + c * s_ds) begin st[c] = 2; idx[c] = lo; sc[c] = 0; end
        else if (st[c] == 2 && idx[c] < hi) begin
          if (sc[c] + 1 >= slw) begin idx[c]++; sc[c] = 0; end
          else sc[c]++;
        end
      end
      if (rise) cnt = 0;
      else if (cnt < 524287) cnt++;
      if (tick) begin pc = 0; ph = (ph == 126) ? 0 : ph + 1; end
      else pc++;
      tq = trig_in ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] exp_pwm;
      for (int c = 0; c < 4; c++) exp_pwm[c] = (ph < cmpv[c]);
      checks++;
      if (pwm_out !== exp_pwm) begin
        failures++;
        $display("FAIL R3/R4 pwm_out actual=%b expected=%b at %0t", pwm_out, exp_pwm, $time);
      end
      checks++;
      if (trig_out !== (st[1] == 2)) begin
        failures++;
        $display("FAIL R8 trig_out actual=%b expected=%b at %0t", trig_out, (st[1] == 2), $time);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic latency_to_out(output int n);
    n = 0;
    do begin
      @(posedge clk); n++; #1;
    end while (!trig_out && n < 3000);
  endtask

  task automatic finish_up;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    int n, bad, hi;
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    // R1: reset state
    check(pwm_out == 4'h0, "R1 pwm after reset", pwm_out, 0);
    check(trig_out == 1'b0, "R1 trig_out after reset", trig_out, 0);

    // Scenario: full-range fade with staggered starts
    cfg_duty_min = 7'd0; cfg_duty_max = 7'd127; cfg_freq = 5'd31;
    cfg_slew = 16'd2; cfg_delay_first = 16'd3; cfg_delay_step = 16'd5;
    cycles(2);
    sm_enable = 1'b1; sm_start = 1'b1;
    cycles(4);
    trig_in = 1'b1;
    latency_to_out(n);
    check(n == 3 + 5 + 2, "R5 channel 1 start latency", n, 10);
    // R2: configuration changes while running are ignored
    cfg_duty_max = 7'd10; cfg_slew = 16'd40; cfg_delay_step = 16'd90;
    cycles(700);
    bad = 0;
    for (int k = 0; k < 127; k++) begin @(negedge clk); if (pwm_out != 4'hF) bad++; end
    check(bad == 0, "R6 ramp settles at max 127 despite R2 input change", bad, 0);

    // R7: fall snaps to minimum and clears trig_out
    @(posedge clk); #1;
    trig_in = 1'b0;
    cycles(2);
    check(trig_out == 1'b0, "R7 trig_out after fall", trig_out, 0);
    cycles(260);
    bad = 0;
    for (int k = 0; k < 127; k++) begin @(negedge clk); if (pwm_out != 4'h0) bad++; end
    check(bad == 0, "R7 outputs at min after fall", bad, 0);

    // R7: mid-sequence fall cancels, new rise restarts from channel 0
    @(posedge clk); #1;
    trig_in = 1'b1;
    cycles(12);
    trig_in = 1'b0;
    cycles(5);
    check(trig_out == 1'b0, "R7 cancelled sequence trig_out", trig_out, 0);
    trig_in = 1'b1;
    latency_to_out(n);
    check(n == 10, "R7 restart latency", n, 10);
    trig_in = 1'b0;
    cycles(3);

    // R2: stopping forces outputs low and reloads shadow
    sm_start = 1'b0;
    cfg_duty_min = 7'd20; cfg_duty_max = 7'd64; cfg_freq = 5'd30;
    cfg_slew = 16'd0; cfg_delay_first = 16'd0; cfg_delay_step = 16'd0;
    cycles(2);
    check(pwm_out == 4'h0, "R2 outputs low while stopped", pwm_out, 0);
    trig_in = 1'b1;
    cycles(3);
    check(trig_out == 1'b0, "R2 trigger ignored while stopped", trig_out, 0);

    // R9: trigger already high at start counts as a rise
    sm_start = 1'b1;
    latency_to_out(n);
    check(n == 2, "R9 start with trigger high", n, 2);
    cycles(800);
    hi = 0;
    for (int k = 0; k < 254; k++) begin @(negedge clk); if (pwm_out[0]) hi++; end
    check(hi == 128, "R3 duty 64 at divider 2 high count", hi, 128);
    hi = 0;
    for (int k = 0; k < 254; k++) begin @(negedge clk); if (pwm_out[3]) hi++; end
    check(hi == 128, "R6 channel 3 settles at max 64", hi, 128);

    // R6: ramp through the table with a slow slew, minimum above zero
    trig_in = 1'b0;
    cycles(600);
    hi = 0;
    for (int k = 0; k < 254; k++) begin @(negedge clk); if (pwm_out[2]) hi++; end
    check(hi == 40, "R7 rest at min 20 at divider 2", hi, 40);
    trig_in = 1'b1;
    cycles(1200);
    trig_in = 1'b0;
    cycles(20);
    finish_up();
  end
endmodule